// File: doc/BRIEF.md
# Vector Memory Address Generator

This block turns one vector load or store into a stream of 64 element addresses. It issues one address per cycle. A single start pulse carries the access mode, a base address, a signed stride and the direction, and the block latches all of them. The block then walks elements 0 through 63. Each address is offered on a valid/ready handshake toward the memory system, and a one-cycle done pulse marks the end of the vector.

Three addressing modes are supported for both directions:
- **Contiguous:** consecutive addresses from the base.
- **Strided:** the base plus a multiple of the stride.
- **Indexed:** the base plus a per-element offset taken from an index vector. An indexed load is a gather and an indexed store is a scatter.

The index vector is read through a narrow read port that returns data combinationally. The block always addresses that port one element ahead of the element on the request port, so an indexed stream has no idle cycles between elements.

Top module: `vag_top`

## Requirements
- R1: While rst_ni is low, and after it rises, req_valid_o and done_o are 0 and idx_addr_o is 0.
- R2: A start_i pulse seen at a clock edge while idle makes req_valid_o 1 after that edge, with req_elem_o equal to 0.
- R3: Mode 2'b00 (contiguous) gives element i the address base + i.
- R4: Mode 2'b01 (strided) gives element i the address base + i*stride, where the stride is signed two's complement.
- R5: Mode 2'b10 (indexed) gives element i the address base + idx_data_i. The value of idx_data_i is the one returned while idx_addr_o equals i. This holds for loads and stores alike.
- R6: Mode 2'b11 behaves exactly as contiguous mode.
- R7: While req_valid_o is 1 and req_ready_i is 0, req_addr_o, req_elem_o and req_valid_o hold their values on the next cycle.
- R8: Each cycle with req_valid_o and req_ready_i both 1 accepts one element, and req_elem_o then advances by one. Under constant ready, all 64 elements go out on 64 consecutive cycles.
- R9: done_o is 1 for exactly the one cycle that follows the acceptance of element 63. req_valid_o is 0 in that cycle.
- R10: A start_i pulse while req_valid_o is 1 has no effect on the address or element sequence in progress.
- R11: All address arithmetic wraps modulo 2^32.
- R12: req_store_o equals store_i as sampled at the accepted start, and it stays unchanged until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a vector access (ignored while busy) |
| mode_i | input | 2 | 00 contiguous, 01 strided, 10 indexed, 11 contiguous |
| store_i | input | 1 | 1 for a store, 0 for a load |
| base_i | input | 32 | Base address |
| stride_i | input | 32 | Signed element stride for strided mode |
| idx_addr_o | output | 6 | Index vector read address |
| idx_data_i | input | 32 | Index vector read data, same cycle |
| req_valid_o | output | 1 | Address request valid |
| req_ready_i | input | 1 | Memory accepts the request |
| req_addr_o | output | 32 | Element address |
| req_elem_o | output | 6 | Element number of the request |
| req_store_o | output | 1 | Direction of the request |
| done_o | output | 1 | One-cycle end-of-vector pulse |

## Verification
The following are checked by assertions on every cycle:
- The handshake contract: requests stay stable under back-pressure, the element number steps by one on each accept, and the request starts at element 0.
- The single-cycle done pulse that follows element 63.
- Address and direction stability between accepts.

The bench scenarios are the only place where the following are shown:
- The full address sequence of each mode, including negative strides.
- Wrap-around past 2^32.
- Gather and scatter against a known index vector.
- Immunity to a start pulse arriving mid-vector.
- The absence of bubbles in a 64-cycle stream.

// File: rtl/vag_pkg.sv
package vag_pkg;
  typedef enum logic [1:0] {
    MODE_UNIT   = 2'b00,
    MODE_STRIDE = 2'b01,
    MODE_INDEX  = 2'b10,
    MODE_ALT    = 2'b11
  } agen_mode_e;
endpackage

// File: rtl/vag_ctrl.sv
module vag_ctrl #(
  parameter int ELEMS = 64,
  localparam int IW = $clog2(ELEMS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic [IW-1:0] elem_o,
  output logic          done_o,
  output logic          launch_o,
  output logic          advance_o
);
  localparam logic [IW-1:0] LAST = IW'(ELEMS - 1);

  logic          busy_q, done_q;
  logic [IW-1:0] elem_q;
  logic          fire, last;

  assign fire      = busy_q & ready_i;
  assign last      = (elem_q == LAST);
  assign launch_o  = start_i & ~busy_q;
  assign advance_o = fire & ~last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      elem_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= fire & last;
      if (launch_o) begin
        busy_q <= 1'b1;
        elem_q <= '0;
      end else if (fire) begin
        if (last) busy_q <= 1'b0;
        else      elem_q <= elem_q + IW'(1);
      end
    end
  end

  assign valid_o = busy_q;
  assign elem_o  = elem_q;
  assign done_o  = done_q;

  AST_HOLD_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(elem_o)) else $error("hold"); // R7
  AST_ELEM_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ready_i && !last |=> valid_o && (elem_o == $past(elem_o) + IW'(1))) else $error("step"); // R8
  AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ready_i && last |=> done_o && !valid_o) else $error("done"); // R9
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o) else $error("pulse"); // R9
  AST_FIRST_ELEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o && start_i |=> valid_o && (elem_o == '0)) else $error("first"); // R2
endmodule

// File: rtl/vag_agen.sv
module vag_agen
  import vag_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          launch_i,
  input  logic          advance_i,
  input  logic [1:0]    mode_i,
  input  logic          store_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] stride_i,
  input  logic [AW-1:0] idx_data_i,
  output logic [AW-1:0] addr_o,
  output logic          store_o
);
  agen_mode_e    mode_in, mode_q;
  logic [AW-1:0] base_q, step_q, addr_q;
  logic          store_q;

  assign mode_in = agen_mode_e'(mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_UNIT;
      base_q  <= '0;
      step_q  <= '0;
      addr_q  <= '0;
      store_q <= 1'b0;
    end else if (launch_i) begin
      mode_q  <= mode_in;
      base_q  <= base_i;
      store_q <= store_i;
      step_q  <= (mode_in == MODE_STRIDE) ? stride_i : AW'(1);
      // index 0 is already on the read port while idle
      addr_q  <= (mode_in == MODE_INDEX) ? base_i + idx_data_i : base_i;
    end else if (advance_i) begin
      addr_q  <= (mode_q == MODE_INDEX) ? base_q + idx_data_i : addr_q + step_q;
    end
  end

  assign addr_o  = addr_q;
  assign store_o = store_q;

  AST_ADDR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !launch_i && !advance_i |=> $stable(addr_o)) else $error("addr"); // R7
  AST_UNIT_BASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i && (mode_i != 2'b10) |=> addr_o == $past(base_i)) else $error("base"); // R3
endmodule

// File: rtl/vag_top.sv
module vag_top #(
  parameter int ELEMS = 64,
  parameter int AW    = 32,
  localparam int IW   = $clog2(ELEMS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    mode_i,
  input  logic          store_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] stride_i,
  output logic [IW-1:0] idx_addr_o,
  input  logic [AW-1:0] idx_data_i,
  output logic          req_valid_o,
  input  logic          req_ready_i,
  output logic [AW-1:0] req_addr_o,
  output logic [IW-1:0] req_elem_o,
  output logic          req_store_o,
  output logic          done_o
);
  logic launch, advance;

  vag_ctrl #(.ELEMS(ELEMS)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .ready_i  (req_ready_i),
    .valid_o  (req_valid_o),
    .elem_o   (req_elem_o),
    .done_o   (done_o),
    .launch_o (launch),
    .advance_o(advance)
  );

  vag_agen #(.AW(AW)) u_agen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .launch_i  (launch),
    .advance_i (advance),
    .mode_i    (mode_i),
    .store_i   (store_i),
    .base_i    (base_i),
    .stride_i  (stride_i),
    .idx_data_i(idx_data_i),
    .addr_o    (req_addr_o),
    .store_o   (req_store_o)
  );

  // read the index one element ahead of the request
  assign idx_addr_o = req_valid_o ? req_elem_o + IW'(1) : '0;

  AST_DIR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |=> $stable(req_store_o)) else $error("dir"); // R12
  AST_IDX_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_o |-> idx_addr_o == '0) else $error("idx"); // R1
endmodule

// File: tb/sim_vag_top.sv
module sim_vag_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 1'b0, store = 1'b0, ready = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [31:0] base = '0, stride = '0;
  logic [5:0]  idx_addr, elem;
  logic [31:0] idx_data, addr;
  logic        valid, st_o, done;
  logic [31:0] idx_mem [64];
  int          errors = 0, checks = 0;
  bit          finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign idx_data = idx_mem[idx_addr];

  vag_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode), .store_i(store),
    .base_i(base), .stride_i(stride), .idx_addr_o(idx_addr), .idx_data_i(idx_data),
    .req_valid_o(valid), .req_ready_i(ready), .req_addr_o(addr), .req_elem_o(elem),
    .req_store_o(st_o), .done_o(done)
  );

  // {mode, store, stall, base, stride}
  localparam logic [67:0] VEC [7] = '{
    {2'b00, 1'b0, 1'b0, 32'h0000_1000, 32'h0000_0000},  // R3 load
    {2'b00, 1'b1, 1'b1, 32'hFFFF_FFF0, 32'h0000_0000},  // R3 R11 store wrap
    {2'b01, 1'b0, 1'b1, 32'h0000_8000, 32'h0000_0008},  // R4
    {2'b01, 1'b1, 1'b0, 32'h0000_0040, 32'hFFFF_FFFC},  // R4 R11 negative
    {2'b10, 1'b0, 1'b0, 32'h0000_2000, 32'h0000_0000},  // R5 gather
    {2'b10, 1'b1, 1'b1, 32'hFFFF_FF00, 32'h0000_0010},  // R5 scatter
    {2'b11, 1'b0, 1'b0, 32'h0000_0300, 32'h0000_0007}   // R6
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(input logic [1:0] m, input logic [31:0] b,
                                           input logic [31:0] s, input int i);
    case (m)
      2'b01:   return b + s * 32'(i);
      2'b10:   return b + idx_mem[i];
      default: return b + 32'(i);
    endcase
  endfunction

  task automatic run_op(input logic [1:0] m, input logic st, input logic stall,
                        input logic [31:0] b, input logic [31:0] s, input int poke);
    int cnt = 0, cyc = 0;
    bit hold = 0;
    logic [31:0] p_addr = '0;
    logic [5:0]  p_elem = '0;
    string tag;
    tag = (m == 2'b01) ? "R4" : (m == 2'b10) ? "R5" : (m == 2'b11) ? "R6" : "R3";
    @(negedge clk);
    mode = m; store = st; base = b; stride = s; start = 1'b1; ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    chk(valid === 1'b1 && elem === 6'd0, "R2 start", {26'd0, elem}, 32'd0);
    while (cnt < 64 && cyc < 400) begin
      ready = stall ? ((cyc % 3) != 2) : 1'b1;
      if (poke >= 0 && cnt == poke) begin
        start = 1'b1; mode = ~m; base = ~b; stride = 32'h55; store = ~st; // R10
      end else begin
        start = 1'b0;
      end
      if (hold) begin
        chk(addr === p_addr && elem === p_elem, "R7 hold", addr, p_addr);
      end
      chk(valid === 1'b1, "R8 valid while busy", {31'd0, valid}, 32'd1);
      if (ready) begin
        chk(elem === 6'(cnt), "R8 elem", {26'd0, elem}, 32'(cnt));
        chk(addr === exp_addr(m, b, s, cnt), poke >= 0 ? "R10 addr" : tag, addr, exp_addr(m, b, s, cnt));
        chk(st_o === st, "R12 dir", {31'd0, st_o}, {31'd0, st});
        cnt++;
      end
      hold = !ready; p_addr = addr; p_elem = elem;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(done === 1'b1 && valid === 1'b0, "R9 done", {30'd0, done, valid}, 32'd2);
    if (!stall) chk(cyc == 64, "R8 no bubble", 32'(cyc), 32'd64);
    @(negedge clk);
    chk(done === 1'b0, "R9 pulse", {31'd0, done}, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++)
      idx_mem[i] = 32'(i) * 32'd292 + ((i % 2 == 1) ? 32'h8000_0000 : 32'd0) + 32'(63 - i);
    #(CLK_PERIOD * 2);
    chk(valid === 1'b0 && done === 1'b0 && idx_addr === 6'd0, "R1 in reset", {31'd0, valid}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(valid === 1'b0 && done === 1'b0 && idx_addr === 6'd0, "R1 after reset", {31'd0, valid}, 32'd0);
    for (int v = 0; v < 7; v++)
      run_op(VEC[v][67:66], VEC[v][65], VEC[v][64], VEC[v][63:32], VEC[v][31:0], -1);
    run_op(2'b01, 1'b0, 1'b1, 32'h0001_0000, 32'h0000_0100, 20);  // R10 busy start
    run_op(2'b10, 1'b1, 1'b0, 32'h0000_0004, 32'h0, 5);           // R10 during scatter
    // reset in mid-vector
    @(negedge clk); start = 1'b1; mode = 2'b00; base = 32'h10; ready = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b0; #1;
    chk(valid === 1'b0 && done === 1'b0 && idx_addr === 6'd0, "R1 async reset", {31'd0, valid}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(valid === 1'b0, "R1 stays idle", {31'd0, valid}, 32'd0);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule